// File: doc/BRIEF.md
# Host Slave Cycle Decoder with Relocatable Register Window

This block sits on the slave side of a host bus interface. Each clock it looks at the host's chip select, memory/IO select, read and write strobes, byte-high enable and 22-bit address. When a valid command arrives while the block is idle, it classifies the cycle. The cycle can be an internal register access, a local-memory access, an ignored cycle or a dummy cycle. The decision depends on whether the address falls inside a relocatable 128-byte register window, and on whether that window sits in memory space or IO space.

An accepted register or memory cycle is passed to the register file or to the memory controller as a level request. The request holds until that target returns a one-cycle done. The block then raises its slave-enable output for exactly one cycle, and the host uses that output as its ready. During an active write, active-low low-byte and high-byte write enables are driven from address bit 0 and the byte-high enable. Only one cycle is in flight at a time. Commands that arrive while a cycle or a dummy is running are dropped. The window base and mapping are loaded through a one-cycle load port.

Top module: `slv_cycle_decode`

## Requirements
- R1: After reset, no request is raised, slave-enable is low, both write enables are high, and the window is memory-mapped at base 0 (window base = address bits 21..7).
- R2: A cycle starts only when chip select (cs_ni) is low and exactly one of rd_ni/wr_ni is low. Both strobes low or both high (idle, halt, interrupt acknowledge) start nothing.
- R3: A memory command (mio_i=1) whose address bits 21..7 equal the window base while the window is memory-mapped raises reg_req_o, with reg_addr_o = address bits 6..0.
- R4: Every other memory command raises mem_req_o, with mem_addr_o equal to the full 22-bit address.
- R5: An IO command (mio_i=0) that hits an IO-mapped window raises reg_req_o.
- R6: An IO command is ignored while the window is memory-mapped: no request, no slave-enable, and the next cycle can accept a new command.
- R7: An IO command that misses an IO-mapped window runs a dummy cycle of exactly two clocks. The dummy raises no request, no write enable and no slave-enable, and commands seen during it are dropped.
- R8: During an active write request, wel_no is low when address bit 0 is 0 and weh_no is low when bhe_ni is 0. During reads both stay high.
- R9: A request holds until its done input is high. Slave-enable is then high for exactly the next cycle, and the request is gone in that cycle.
- R10: Commands are not queued. A command presented while a request is pending is dropped and never produces a request.
- R11: reg_we_o and mem_we_o are high only for a write, and at most one of reg_req_o and mem_req_o is high.
- R12: A one-cycle reloc_ld_i loads the window base and the IO-mapping bit, and later commands decode against the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| mio_i | input | 1 | 1 = memory command, 0 = IO command |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| bhe_ni | input | 1 | Byte-high enable, active low |
| addr_i | input | 22 | Host address |
| reloc_ld_i | input | 1 | Load window base and mapping |
| reloc_base_i | input | 15 | New window base (address bits 21..7) |
| reloc_io_i | input | 1 | New mapping: 1 = IO space |
| reg_req_o | output | 1 | Register-file request |
| reg_we_o | output | 1 | Register request is a write |
| reg_addr_o | output | 7 | Offset within the window |
| reg_done_i | input | 1 | Register access complete |
| mem_req_o | output | 1 | Local-memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 22 | Memory address |
| mem_done_i | input | 1 | Memory access complete |
| wel_no | output | 1 | Low-byte write enable, active low |
| weh_no | output | 1 | High-byte write enable, active low |
| sen_o | output | 1 | Slave enable / host ready pulse |

## Verification
A wrong relocation value or a wrong mapping bit shows in the cycle after acceptance: the request appears on the wrong target, or is missing. A stale latched address or direction shows on the same request outputs and on the byte enables while the request is held. A faulty busy or dummy state shows within two to three clocks, either as a dropped command that still produces a request or as a probe command that is not accepted right after a dummy. Completion faults show one cycle after done, as a missing, repeated or early slave-enable pulse.

// File: rtl/slv_pkg.sv
package slv_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_REG   = 2'd1,
    ACT_MEM   = 2'd2,
    ACT_DUMMY = 2'd3
  } act_e;
endpackage

// File: rtl/slv_window_cmp.sv
module slv_window_cmp #(
  parameter int ADDR_W   = 22,
  parameter int WIN_BITS = 7,
  localparam int HI_W    = ADDR_W - WIN_BITS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_i,
  input  logic [HI_W-1:0] base_i,
  input  logic            io_i,
  input  logic [HI_W-1:0] addr_hi_i,
  output logic            hit_o,
  output logic            io_map_o
);
  logic [HI_W-1:0] base_q;
  logic            io_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      io_q   <= 1'b0;
    end else if (ld_i) begin
      base_q <= base_i;
      io_q   <= io_i;
    end
  end

  assign hit_o    = (addr_hi_i == base_q);
  assign io_map_o = io_q;
endmodule

// File: rtl/slv_cmd_decode.sv
module slv_cmd_decode
  import slv_pkg::*;
(
  input  logic cs_ni,
  input  logic mio_i,
  input  logic rd_ni,
  input  logic wr_ni,
  input  logic hit_i,
  input  logic io_map_i,
  output act_e act_o,
  output logic we_o
);
  logic valid;

  // exactly one strobe active; same-level pairs are idle/halt/inta
  assign valid = !cs_ni && (rd_ni ^ wr_ni);
  assign we_o  = !wr_ni;

  always_comb begin
    act_o = ACT_NONE;
    if (valid) begin
      if (mio_i)         act_o = (hit_i && !io_map_i) ? ACT_REG : ACT_MEM;
      else if (io_map_i) act_o = hit_i ? ACT_REG : ACT_DUMMY;
      else               act_o = ACT_NONE;
    end
  end
endmodule

// File: rtl/slv_cycle_fsm.sv
module slv_cycle_fsm
  import slv_pkg::*;
#(
  parameter int ADDR_W       = 22,
  parameter int WIN_BITS     = 7,
  parameter int DUMMY_CYCLES = 2,
  localparam int CNT_W       = $clog2(DUMMY_CYCLES + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  act_e                act_i,
  input  logic                we_i,
  input  logic                bhe_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                reg_req_o,
  output logic                reg_we_o,
  output logic [WIN_BITS-1:0] reg_addr_o,
  input  logic                reg_done_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  input  logic                mem_done_i,
  output logic                wel_no,
  output logic                weh_no,
  output logic                sen_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DUMMY} st_e;

  st_e               st_q;
  logic              is_reg_q, we_q, bhe_n_q, sen_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done, busy;

  assign busy = (st_q == ST_BUSY);
  assign done = is_reg_q ? reg_done_i : mem_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      is_reg_q <= 1'b0;
      we_q     <= 1'b0;
      bhe_n_q  <= 1'b1;
      addr_q   <= '0;
      cnt_q    <= '0;
      sen_q    <= 1'b0;
    end else begin
      sen_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (act_i == ACT_REG || act_i == ACT_MEM) begin
            st_q     <= ST_BUSY;
            is_reg_q <= (act_i == ACT_REG);
            we_q     <= we_i;
            bhe_n_q  <= bhe_ni;
            addr_q   <= addr_i;
          end else if (act_i == ACT_DUMMY) begin
            st_q  <= ST_DUMMY;
            cnt_q <= '0;
          end
        end
        ST_BUSY: begin
          if (done) begin
            st_q  <= ST_IDLE;
            sen_q <= 1'b1;
          end
        end
        ST_DUMMY: begin
          if (cnt_q == CNT_W'(DUMMY_CYCLES - 1)) st_q <= ST_IDLE;
          else                                   cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign reg_req_o  = busy && is_reg_q;
  assign mem_req_o  = busy && !is_reg_q;
  assign reg_we_o   = reg_req_o && we_q;
  assign mem_we_o   = mem_req_o && we_q;
  assign reg_addr_o = addr_q[WIN_BITS-1:0];
  assign mem_addr_o = addr_q;
  assign wel_no     = !(busy && we_q && !addr_q[0]);
  assign weh_no     = !(busy && we_q && !bhe_n_q);
  assign sen_o      = sen_q;
endmodule

// File: rtl/slv_cycle_decode.sv
module slv_cycle_decode
  import slv_pkg::*;
#(
  parameter int ADDR_W       = 22,
  parameter int WIN_BITS     = 7,
  parameter int DUMMY_CYCLES = 2,
  localparam int HI_W        = ADDR_W - WIN_BITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                mio_i,
  input  logic                rd_ni,
  input  logic                wr_ni,
  input  logic                bhe_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                reloc_ld_i,
  input  logic [HI_W-1:0]     reloc_base_i,
  input  logic                reloc_io_i,
  output logic                reg_req_o,
  output logic                reg_we_o,
  output logic [WIN_BITS-1:0] reg_addr_o,
  input  logic                reg_done_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  input  logic                mem_done_i,
  output logic                wel_no,
  output logic                weh_no,
  output logic                sen_o
);
  logic hit, io_map, we;
  act_e act;

  slv_window_cmp #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (reloc_ld_i),
    .base_i    (reloc_base_i),
    .io_i      (reloc_io_i),
    .addr_hi_i (addr_i[ADDR_W-1:WIN_BITS]),
    .hit_o     (hit),
    .io_map_o  (io_map)
  );

  slv_cmd_decode u_dec (
    .cs_ni    (cs_ni),
    .mio_i    (mio_i),
    .rd_ni    (rd_ni),
    .wr_ni    (wr_ni),
    .hit_i    (hit),
    .io_map_i (io_map),
    .act_o    (act),
    .we_o     (we)
  );

  slv_cycle_fsm #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .DUMMY_CYCLES(DUMMY_CYCLES)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .we_i       (we),
    .bhe_ni     (bhe_ni),
    .addr_i     (addr_i),
    .reg_req_o  (reg_req_o),
    .reg_we_o   (reg_we_o),
    .reg_addr_o (reg_addr_o),
    .reg_done_i (reg_done_i),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_done_i (mem_done_i),
    .wel_no     (wel_no),
    .weh_no     (weh_no),
    .sen_o      (sen_o)
  );
endmodule

// File: rtl/slv_cycle_decode_chk.sv
module slv_cycle_decode_chk #(
  parameter int ADDR_W = 22
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_req_o,
  input logic              reg_we_o,
  input logic              reg_done_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_done_i,
  input logic              wel_no,
  input logic              weh_no,
  input logic              sen_o
);
  p_one_target_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_req_o && mem_req_o));

  p_we_needs_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o || mem_we_o) |-> (reg_req_o || mem_req_o));

  p_reg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_o && !reg_done_i) |=> reg_req_o);

  p_mem_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_done_i) |=> mem_req_o);

  p_sen_after_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((reg_req_o && reg_done_i) || (mem_req_o && mem_done_i))
      |=> (sen_o && !reg_req_o && !mem_req_o));

  p_sen_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sen_o |=> !sen_o);

  p_byte_we_active_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wel_no || !weh_no) |-> (reg_we_o || mem_we_o));

  p_addr_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |-> $stable(mem_addr_o));
endmodule

bind slv_cycle_decode slv_cycle_decode_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_req_o  (reg_req_o),
  .reg_we_o   (reg_we_o),
  .reg_done_i (reg_done_i),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_done_i (mem_done_i),
  .wel_no     (wel_no),
  .weh_no     (weh_no),
  .sen_o      (sen_o)
);

// File: tb/slv_cycle_decode_tb.sv
module slv_cycle_decode_tb;
  localparam int AW = 22;
  localparam int WB = 7;
  localparam int HW = AW - WB;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic          cs_ni, mio_i, rd_ni, wr_ni, bhe_ni;
  logic [AW-1:0] addr_i;
  logic          reloc_ld_i, reloc_io_i;
  logic [HW-1:0] reloc_base_i;
  logic          reg_req_o, reg_we_o, reg_done_i;
  logic [WB-1:0] reg_addr_o;
  logic          mem_req_o, mem_we_o, mem_done_i;
  logic [AW-1:0] mem_addr_o;
  logic          wel_no, weh_no, sen_o;

  slv_cycle_decode u_dut (.*);

  int checks = 0;
  int errors = 0;
  logic [HW-1:0] m_base = '0;
  logic          m_io   = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // 0 none, 1 register, 2 memory, 3 dummy
  function automatic int exp_act(input bit cs_n, input bit mio, input bit rd_n,
                                 input bit wr_n, input logic [AW-1:0] a);
    bit hit;
    hit = (a[AW-1:WB] == m_base);
    if (cs_n || (rd_n == wr_n)) return 0;
    if (mio) return (hit && !m_io) ? 1 : 2;
    if (!m_io) return 0;
    return hit ? 1 : 3;
  endfunction

  task automatic bus_idle();
    cs_ni = 1'b1; rd_ni = 1'b1; wr_ni = 1'b1; mio_i = 1'b1; bhe_ni = 1'b1;
  endtask

  task automatic drive(input bit cs_n, input bit mio, input bit rd_n, input bit wr_n,
                       input bit bhe_n, input logic [AW-1:0] a);
    cs_ni = cs_n; mio_i = mio; rd_ni = rd_n; wr_ni = wr_n; bhe_ni = bhe_n; addr_i = a;
  endtask

  task automatic reloc(input logic [HW-1:0] b, input bit io);
    @(negedge clk_i);
    reloc_ld_i = 1'b1; reloc_base_i = b; reloc_io_i = io;
    @(negedge clk_i);
    reloc_ld_i = 1'b0;
    m_base = b; m_io = io;
  endtask

  task automatic finish_req(input bit is_reg, input int dly, input string tag);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk_i);
      bus_idle();
      chk(is_reg ? reg_req_o : mem_req_o, {tag, " R9 hold"}, 0, 1);
      chk(!sen_o, "R9 early sen", sen_o, 0);
    end
    if (is_reg) reg_done_i = 1'b1; else mem_done_i = 1'b1;
    @(negedge clk_i);
    reg_done_i = 1'b0; mem_done_i = 1'b0;
    bus_idle();
    chk(sen_o == 1'b1, "R9 sen pulse", sen_o, 1);
    chk(!reg_req_o && !mem_req_o, "R9 req drop", {reg_req_o, mem_req_o}, 0);
    @(negedge clk_i);
    chk(!sen_o, "R9 sen one cycle", sen_o, 0);
    chk(!reg_req_o && !mem_req_o, "R10 no queued req", {reg_req_o, mem_req_o}, 0);
  endtask

  task automatic do_cmd(input bit cs_n, input bit mio, input bit rd_n, input bit wr_n,
                        input bit bhe_n, input logic [AW-1:0] a, input int dly);
    int k;
    bit wr;
    k  = exp_act(cs_n, mio, rd_n, wr_n, a);
    wr = (k != 0) && !wr_n;
    @(negedge clk_i);
    drive(cs_n, mio, rd_n, wr_n, bhe_n, a);
    @(negedge clk_i);
    bus_idle();
    case (k)
      0: begin
        chk(!reg_req_o && !mem_req_o, "R2 R6 no request", {reg_req_o, mem_req_o}, 0);
        chk(!sen_o, "R6 no sen", sen_o, 0);
      end
      1, 2: begin
        // stray command while busy must be dropped (R10)
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, a ^ 22'h155);
        chk(reg_req_o == (k == 1), "R3 R5 reg_req", reg_req_o, k == 1);
        chk(mem_req_o == (k == 2), "R4 mem_req", mem_req_o, k == 2);
        if (k == 1) begin
          chk(reg_addr_o == a[WB-1:0], "R3 reg_addr", reg_addr_o, a[WB-1:0]);
          chk(reg_we_o == wr, "R11 reg_we", reg_we_o, wr);
        end else begin
          chk(mem_addr_o == a, "R4 mem_addr", mem_addr_o, a);
          chk(mem_we_o == wr, "R11 mem_we", mem_we_o, wr);
        end
        chk(wel_no == !(wr && !a[0]), "R8 wel", wel_no, !(wr && !a[0]));
        chk(weh_no == !(wr && !bhe_n), "R8 weh", weh_no, !(wr && !bhe_n));
        finish_req(k == 1, dly, k == 1 ? "R3" : "R4");
      end
      default: begin
        chk(!reg_req_o && !mem_req_o, "R7 dummy no req", {reg_req_o, mem_req_o}, 0);
        chk(wel_no && weh_no, "R7 dummy no we", {wel_no, weh_no}, 3);
        chk(!sen_o, "R7 dummy no sen", sen_o, 0);
        @(negedge clk_i);
        // second dummy clock: this command must be dropped
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, a);
        chk(!sen_o && wel_no && weh_no, "R7 dummy clk2", {sen_o, wel_no, weh_no}, 3);
        @(negedge clk_i);
        chk(!reg_req_o && !mem_req_o, "R7 dropped in dummy", {reg_req_o, mem_req_o}, 0);
        chk(!sen_o, "R7 no sen at end", sen_o, 0);
        // probe: accepted right after two dummy clocks (window IO-mapped -> memory)
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, a);
        @(negedge clk_i);
        bus_idle();
        chk(mem_req_o, "R7 dummy length", mem_req_o, 1);
        finish_req(1'b0, 0, "R7");
      end
    endcase
  endtask

  function automatic logic [AW-1:0] pick_addr();
    if ($urandom_range(0, 1) == 0) return {m_base, 7'($urandom)};
    return AW'($urandom);
  endfunction

  bit done_flag = 1'b0;

  initial begin
    void'($urandom(32'h5EED_0C0D));
    bus_idle();
    addr_i = '0; reloc_ld_i = 1'b0; reloc_base_i = '0; reloc_io_i = 1'b0;
    reg_done_i = 1'b0; mem_done_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!reg_req_o && !mem_req_o, "R1 reset req", {reg_req_o, mem_req_o}, 0);
    chk(!sen_o && wel_no && weh_no, "R1 reset outs", {sen_o, wel_no, weh_no}, 3);

    // R1: base 0, memory-mapped -> address 0x40 goes to registers
    do_cmd(0, 1, 0, 1, 1, 22'h000040, 1);
    // R2: strobes both active / both inactive / cs high
    do_cmd(0, 1, 0, 0, 0, 22'h000010, 0);
    do_cmd(0, 0, 1, 1, 0, 22'h000010, 0);
    do_cmd(1, 1, 0, 1, 0, 22'h000010, 0);
    // R6: IO while memory-mapped is ignored, next command accepted at once
    do_cmd(0, 0, 1, 0, 0, 22'h000002, 0);
    do_cmd(0, 1, 1, 0, 0, 22'h000081, 2);
    // R8: byte lanes on writes
    do_cmd(0, 1, 1, 0, 1, 22'h100000, 0);
    do_cmd(0, 1, 1, 0, 0, 22'h100001, 3);
    // R12: relocate to IO space
    reloc(15'h07FB, 1'b1);
    do_cmd(0, 0, 1, 0, 0, {15'h07FB, 7'h12}, 1);
    do_cmd(0, 1, 0, 1, 0, {15'h07FB, 7'h12}, 0);
    do_cmd(0, 0, 0, 1, 1, {15'h07FA, 7'h7F}, 0);
    reloc(15'h3FFF, 1'b0);
    do_cmd(0, 1, 1, 0, 0, 22'h3FFFFE, 0);

    for (int it = 0; it < 400; it++) begin
      if ($urandom_range(0, 39) == 0) reloc(HW'($urandom), 1'($urandom));
      do_cmd($urandom_range(0, 9) == 0, 1'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom), pick_addr(), $urandom_range(0, 3));
    end
    done_flag = 1'b1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (150000) @(posedge clk_i);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule